// File: doc/BRIEF.md
# NAND Flash Bus Controller with ECC

This block connects a byte-wide host register port to a raw NAND flash device. Software sequences every flash command itself. It sets the command-latch, address-latch, chip-enable and write-protect pin levels through a control register, then moves bytes through a data register. Each host access to the data register produces a one-cycle strobe on the flash side: a write strobe with the byte on the output bus, or a read strobe while the byte on the input bus is returned to the host.

Every byte that crosses the data register, in either direction, also enters a running Hamming accumulator sized for a 256-byte block. The accumulator keeps a byte count, six column-parity bits, and two 8-bit line-parity words. Bits of the even word toggle for positions whose index bit is 0. Bits of the odd word toggle for positions whose index bit is 1. Software reads the count and the parities, compares them with the spare-area code, and clears the accumulator before the next block.

Top module: `nfc_flash_ctrl`

## Requirements
- R1: After reset the stored control value is 0, so all pin outputs are 0. The byte count, both line-parity words and the column parity are also 0.
- R2: A write to offset 0x18 stores the written byte with bit 5 forced to 0. From the next cycle the pins follow the stored bits: nf_ce_n[0] = bit0, nf_cle = bit1, nf_ale = bit2, nf_wp = bit3, nf_ce_n[1] = bit4.
- R3: A read of offset 0x18 returns the stored control byte, with bit 5 replaced by the level of nf_rdy in the same cycle.
- R4: A write to offset 0x14 asserts nf_we_stb for that cycle, with nf_dq_out equal to the written byte. That byte is added to the accumulator at the clock edge.
- R5: A read of offset 0x14 asserts nf_re_stb for that cycle and returns nf_dq_in unchanged. That byte is added to the accumulator. nf_we_stb and nf_re_stb are never high together.
- R6: Offset 0x0C returns the low 8 bits of the number of bytes digested since the last clear. After 256 bytes it wraps to 0.
- R7: Offset 0x08 returns the accumulated column parity in bits 5:0. For j = 0..2, bit 2j is the XOR of data bits whose index has bit j equal to 0, and bit 2j+1 is the XOR of data bits whose index has bit j equal to 1.
- R8: A byte with odd bit parity at position p (the count before it) toggles even[i] for each i where p bit i is 0, and odd[i] for each i where p bit i is 1. A byte with even parity leaves both words unchanged.
- R9: Offset 0x00 returns even[4+k] in bit 2k and odd[4+k] in bit 2k+1, for k = 0..3. Offset 0x04 returns even[k] in bit 2k and odd[k] in bit 2k+1.
- R10: Any write to offset 0x10 zeroes the count and all parity, whatever the written value. The control value is not changed.
- R11: A read of any other offset returns 0. A write to any other offset changes neither the control value nor the accumulator.
- R12: Accesses to offsets 0x00, 0x04, 0x08, 0x0C and 0x18 do not change the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset of the register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the access cycle |
| nf_ce_n | output | 2 | Chip-enable pin levels (bit4, bit0 of control) |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_wp | output | 1 | Write-protect pin level |
| nf_dq_out | output | 8 | Byte driven to the flash |
| nf_we_stb | output | 1 | Flash write strobe |
| nf_dq_in | input | 8 | Byte returned by the flash |
| nf_re_stb | output | 1 | Flash read strobe |
| nf_rdy | input | 1 | Ready/busy level from the flash |

## Verification
The control path and the live ready/busy input meet in a single cycle. A control write carrying bit 5 set is followed by a control read, and nf_rdy changes between the two. The read must show the fresh nf_rdy level in bit 5 and never the written bit. The bench also places a data-register digest directly before a clear and directly after one, and checks that no partial byte survives the clear.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;
  localparam int unsigned HOST_AW = 5;

  typedef enum logic [HOST_AW-1:0] {
    OFF_LP_UPPER = 5'h00,
    OFF_LP_LOWER = 5'h04,
    OFF_COLPAR   = 5'h08,
    OFF_COUNT    = 5'h0C,
    OFF_CLEAR    = 5'h10,
    OFF_DATA     = 5'h14,
    OFF_CONTROL  = 5'h18
  } nfc_off_e;

  // Control byte bit positions (R2, R3)
  localparam int unsigned CB_CE0  = 0;
  localparam int unsigned CB_CLE  = 1;
  localparam int unsigned CB_ALE  = 2;
  localparam int unsigned CB_WP   = 3;
  localparam int unsigned CB_CE1  = 4;
  localparam int unsigned CB_BUSY = 5;
endpackage

// File: rtl/nfc_ecc_acc.sv
`timescale 1ns/1ps
module nfc_ecc_acc #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BLOCK_BYTES = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                dig_i,
  input  logic [DATA_W-1:0]   byte_i,
  output logic [$clog2(BLOCK_BYTES)-1:0] cnt_o,
  output logic [$clog2(BLOCK_BYTES)-1:0] lp_even_o,
  output logic [$clog2(BLOCK_BYTES)-1:0] lp_odd_o,
  output logic [2*$clog2(DATA_W)-1:0]    cp_o
);
  localparam int unsigned POS_W = $clog2(BLOCK_BYTES);
  localparam int unsigned LOG_D = $clog2(DATA_W);
  localparam int unsigned CP_W  = 2*LOG_D;

  logic [POS_W-1:0] cnt_q, cnt_d;
  logic [POS_W-1:0] lpe_q, lpe_d, lpo_q, lpo_d;
  logic [CP_W-1:0]  cp_q, cp_d, cp_byte;
  logic             par;
  logic             en;

  // Column split of one byte (R7)
  always_comb begin
    cp_byte = '0;
    for (int j = 0; j < int'(LOG_D); j++) begin
      for (int b = 0; b < int'(DATA_W); b++) begin
        if (((b >> j) & 1) == 1) cp_byte[2*j+1] = cp_byte[2*j+1] ^ byte_i[b];
        else                     cp_byte[2*j]   = cp_byte[2*j]   ^ byte_i[b];
      end
    end
  end

  assign par = ^byte_i;
  assign en  = clr_i | dig_i;

  // Next state: clear wins, else digest at position cnt_q (R6, R8, R10)
  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
      lpe_d = '0;
      lpo_d = '0;
      cp_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      lpe_d = lpe_q ^ ({POS_W{par}} & ~cnt_q);
      lpo_d = lpo_q ^ ({POS_W{par}} &  cnt_q);
      cp_d  = cp_q ^ cp_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lpe_q <= '0;
      lpo_q <= '0;
      cp_q  <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      lpe_q <= lpe_d;
      lpo_q <= lpo_d;
      cp_q  <= cp_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign lp_even_o = lpe_q;
  assign lp_odd_o  = lpo_q;
  assign cp_o      = cp_q;

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    dig_i && !clr_i |=> cnt_q == POS_W'($past(cnt_q) + 1'b1));
  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0 && lpe_q == '0 && lpo_q == '0 && cp_q == '0);
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_i && !clr_i |=> $stable(cnt_q) && $stable(cp_q) && $stable(lpe_q) && $stable(lpo_q));
  a_r8_even_byte_keeps_lines: assert property (@(posedge clk) disable iff (!rst_n)
    dig_i && !clr_i && !(^byte_i) |=> $stable(lpe_q) && $stable(lpo_q));
  a_r8_odd_byte_flips_one_per_bit: assert property (@(posedge clk) disable iff (!rst_n)
    dig_i && !clr_i && (^byte_i) |=>
      $countones((lpe_q ^ $past(lpe_q)) | (lpo_q ^ $past(lpo_q))) == POS_W);
endmodule

// File: rtl/nfc_pin_ctl.sv
`timescale 1ns/1ps
module nfc_pin_ctl
  import nfc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic [1:0]        ce_n_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              wp_o
);
  localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << CB_BUSY;

  logic [DATA_W-1:0] ctl_q, ctl_d;

  // R2: the busy position is never stored
  always_comb begin
    ctl_d = wdata_i & ~BUSY_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_q <= '0;
    else if (wr_i) ctl_q <= ctl_d;
  end

  assign ctl_o     = ctl_q;
  assign ce_n_o[0] = ctl_q[CB_CE0];
  assign ce_n_o[1] = ctl_q[CB_CE1];
  assign cle_o     = ctl_q[CB_CLE];
  assign ale_o     = ctl_q[CB_ALE];
  assign wp_o      = ctl_q[CB_WP];

  a_r2_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ce_n_o) && $stable(cle_o) && $stable(ale_o) && $stable(wp_o));
endmodule

// File: rtl/nfc_flash_ctrl.sv
`timescale 1ns/1ps
module nfc_flash_ctrl
  import nfc_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BLOCK_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [4:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [1:0]        nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_wp,
  output logic [DATA_W-1:0] nf_dq_out,
  output logic              nf_we_stb,
  input  logic [DATA_W-1:0] nf_dq_in,
  output logic              nf_re_stb,
  input  logic              nf_rdy
);
  localparam int unsigned POS_W = $clog2(BLOCK_BYTES);
  localparam int unsigned HALF  = POS_W/2;
  localparam int unsigned CP_W  = 2*$clog2(DATA_W);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // Decode
  logic wr_acc, rd_acc;
  logic ctl_wr, clr_wr, io_wr, io_rd, dig;
  assign wr_acc = host_sel &  host_wr;
  assign rd_acc = host_sel & ~host_wr;
  assign ctl_wr = wr_acc && (host_addr == OFF_CONTROL);
  assign clr_wr = wr_acc && (host_addr == OFF_CLEAR);   // R10
  assign io_wr  = wr_acc && (host_addr == OFF_DATA);    // R4
  assign io_rd  = rd_acc && (host_addr == OFF_DATA);    // R5
  assign dig    = io_wr | io_rd;

  logic [DATA_W-1:0] dig_byte;
  assign dig_byte = io_wr ? host_wdata : nf_dq_in;

  logic [DATA_W-1:0] ctl_val;
  nfc_pin_ctl #(.DATA_W(DATA_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (ctl_wr),
    .wdata_i (host_wdata),
    .ctl_o   (ctl_val),
    .ce_n_o  (nf_ce_n),
    .cle_o   (nf_cle),
    .ale_o   (nf_ale),
    .wp_o    (nf_wp)
  );

  logic [POS_W-1:0] cnt, lp_even, lp_odd;
  logic [CP_W-1:0]  colpar;
  nfc_ecc_acc #(.DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)) u_ecc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (clr_wr),
    .dig_i     (dig),
    .byte_i    (dig_byte),
    .cnt_o     (cnt),
    .lp_even_o (lp_even),
    .lp_odd_o  (lp_odd),
    .cp_o      (colpar)
  );

  // R9: interleave even/odd line parity
  logic [2*HALF-1:0] lp_up_pack, lp_lo_pack;
  for (genvar k = 0; k < HALF; k++) begin : g_pack
    assign lp_up_pack[2*k]   = lp_even[HALF+k];
    assign lp_up_pack[2*k+1] = lp_odd[HALF+k];
    assign lp_lo_pack[2*k]   = lp_even[k];
    assign lp_lo_pack[2*k+1] = lp_odd[k];
  end

  // Read mux (R3, R6, R7, R11)
  always_comb begin
    host_rdata = '0;
    if (rd_acc) begin
      case (host_addr)
        OFF_LP_UPPER: host_rdata = DATA_W'(lp_up_pack);
        OFF_LP_LOWER: host_rdata = DATA_W'(lp_lo_pack);
        OFF_COLPAR:   host_rdata = DATA_W'(colpar);
        OFF_COUNT:    host_rdata = DATA_W'(cnt);
        OFF_DATA:     host_rdata = nf_dq_in;
        OFF_CONTROL: begin
          host_rdata          = ctl_val;
          host_rdata[CB_BUSY] = nf_rdy;
        end
        default:      host_rdata = '0;
      endcase
    end
  end

  assign nf_we_stb = io_wr;
  assign nf_re_stb = io_rd;
  assign nf_dq_out = io_wr ? host_wdata : '0;

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(nf_we_stb && nf_re_stb));
  a_r2_control_holds_on_unmapped: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_acc && host_addr == 5'h1C |=> $stable(nf_cle) && $stable(nf_ce_n));
endmodule

// File: tb/tb_nfc_flash_ctrl.sv
`timescale 1ns/1ps
module tb_nfc_flash_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_sel, host_wr;
  logic [4:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic [1:0] nf_ce_n;
  logic       nf_cle, nf_ale, nf_wp, nf_we_stb, nf_re_stb, nf_rdy;
  logic [7:0] nf_dq_out, nf_dq_in;

  always #4 clk = ~clk;

  nfc_flash_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_wp(nf_wp),
    .nf_dq_out(nf_dq_out), .nf_we_stb(nf_we_stb), .nf_dq_in(nf_dq_in),
    .nf_re_stb(nf_re_stb), .nf_rdy(nf_rdy)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Independent model of the accumulator
  logic [7:0] m_cnt, m_even, m_odd;
  logic [5:0] m_cp;

  logic [7:0] rd;
  logic       seen_we, seen_re;
  logic [7:0] seen_dq;

  localparam logic [7:0] VEC [16] = '{
    8'h00, 8'h01, 8'hFF, 8'h80, 8'h7F, 8'hA5, 8'h3C, 8'h10,
    8'hE7, 8'h02, 8'h55, 8'hC3, 8'h08, 8'h9A, 8'h40, 8'hFE
  };

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", what, got, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_even = 0; m_odd = 0; m_cp = 0;
  endtask

  task automatic model_byte(input logic [7:0] b);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 8; i++) p = p ^ b[i];
    for (int i = 0; i < 8; i++) begin
      if (m_cnt[i]) m_odd[i]  = m_odd[i] ^ p;
      else          m_even[i] = m_even[i] ^ p;
    end
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 8; i++)
        if (((i >> j) & 1) == 1) m_cp[2*j+1] = m_cp[2*j+1] ^ b[i];
        else                     m_cp[2*j]   = m_cp[2*j]   ^ b[i];
    m_cnt = m_cnt + 8'd1;
  endtask

  function automatic logic [7:0] pack(input logic [7:0] e, input logic [7:0] o, input int base);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) begin
      r[2*k]   = e[base+k];
      r[2*k+1] = o[base+k];
    end
    return r;
  endfunction

  task automatic bus(input logic wr, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    #1;
    rd = host_rdata; seen_we = nf_we_stb; seen_re = nf_re_stb; seen_dq = nf_dq_out;
    @(posedge clk);
    #1;
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic check_ecc(input string tag);
    bus(1'b0, 5'h0C, 8'h00); chk({tag, " R6 count"}, rd, m_cnt);
    bus(1'b0, 5'h08, 8'h00); chk({tag, " R7 column parity"}, rd, {2'b00, m_cp});
    bus(1'b0, 5'h00, 8'h00); chk({tag, " R9 upper lines"}, rd, pack(m_even, m_odd, 4));
    bus(1'b0, 5'h04, 8'h00); chk({tag, " R8 R9 lower lines"}, rd, pack(m_even, m_odd, 0));
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    nf_dq_in = 8'h00; nf_rdy = 1'b0;
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    @(negedge clk);
    chk("R1 pins", {2'b00, nf_ce_n, nf_cle, nf_ale, nf_wp, 1'b0}, 8'h00);
    bus(1'b0, 5'h18, 8'h00); chk("R1 control", rd, 8'h00);
    check_ecc("R1");

    // Vector table: bytes through the data register (R4, R6)
    for (int i = 0; i < 16; i++) begin
      bus(1'b1, 5'h14, VEC[i]);
      chk("R4 write strobe", {7'd0, seen_we}, 8'h01);
      chk("R4 dq_out", seen_dq, VEC[i]);
      model_byte(VEC[i]);
      bus(1'b0, 5'h0C, 8'h00);
      chk("R6 running count", rd, m_cnt);
    end
    check_ecc("table");
    // R12: reads of ECC registers did not digest
    bus(1'b0, 5'h0C, 8'h00); chk("R12 count unchanged", rd, m_cnt);

    // R2, R3: control with busy bit and live ready/busy
    bus(1'b1, 5'h18, 8'h3F);
    @(negedge clk);
    chk("R2 pins", {3'b000, nf_ce_n[1], nf_wp, nf_ale, nf_cle, nf_ce_n[0]}, 8'h1F);
    bus(1'b0, 5'h18, 8'h00); chk("R3 control rdy=0", rd, 8'h1F);
    nf_rdy = 1'b1;
    bus(1'b0, 5'h18, 8'h00); chk("R3 control rdy=1", rd, 8'h3F);
    bus(1'b1, 5'h18, 8'h12);
    @(negedge clk);
    chk("R2 pins second", {3'b000, nf_ce_n[1], nf_wp, nf_ale, nf_cle, nf_ce_n[0]}, 8'h12);
    nf_rdy = 1'b0;
    bus(1'b0, 5'h18, 8'h00); chk("R3 busy bit follows input", rd, 8'h12);

    // R10: clear with arbitrary value, control untouched
    bus(1'b1, 5'h14, 8'h01); model_byte(8'h01);
    bus(1'b1, 5'h10, 8'hA5); model_clear();
    check_ecc("R10");
    bus(1'b0, 5'h18, 8'h00); chk("R10 control kept", rd, 8'h12);

    // R5: read path digest
    nf_dq_in = 8'h96;
    bus(1'b0, 5'h14, 8'h00);
    chk("R5 read data", rd, 8'h96);
    chk("R5 strobes", {6'd0, seen_we, seen_re}, 8'h01);
    model_byte(8'h96);
    nf_dq_in = 8'h07;
    bus(1'b0, 5'h14, 8'h00); model_byte(8'h07);
    bus(1'b1, 5'h14, 8'hF1); model_byte(8'hF1);
    check_ecc("R5");

    // R11: unmapped offsets
    bus(1'b1, 5'h1C, 8'hFF);
    bus(1'b0, 5'h18, 8'h00); chk("R11 control after stray write", rd, 8'h12);
    bus(1'b0, 5'h0C, 8'h00); chk("R11 count after stray write", rd, m_cnt);
    bus(1'b0, 5'h1C, 8'h00); chk("R11 unmapped read", rd, 8'h00);
    bus(1'b0, 5'h02, 8'h00); chk("R11 misaligned read", rd, 8'h00);

    // R6, R8: full block wraps the count
    bus(1'b1, 5'h10, 8'h00); model_clear();
    for (int i = 0; i < 256; i++) begin
      bus(1'b1, 5'h14, 8'(i) ^ 8'h5A);
      model_byte(8'(i) ^ 8'h5A);
    end
    check_ecc("wrap");
    chk("R6 wrapped to zero", m_cnt, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule